// File: doc/BRIEF.md
# Multi-source reset controller

This block merges four reset causes into one internal reset for a small 16-bit microcontroller core: an external reset pin, a software request (a one-cycle pulse raised when software writes 1 to a control bit), a watchdog underflow and a main-oscillator stop detection. The watchdog cause is gated by a select input and the oscillator cause by a mode input. While reset is active the block drives `sys_rst_o`. This clears the CPU registers to 0000h and resets the pins and the general peripheral registers. It also drives `prot_rst_o`, which reaches a protected group of peripheral registers only on a pin reset.

After reset is released, the block reads the 20-bit start address from the reset vector through two 16-bit bus reads and presents it on `pc_o`. Only then does it raise `cpu_en_o`. A cause register records the source that triggered the last reset. The 2-bit processor-mode field is also held here. A pin reset (or the power-on reset `rst_ni`) clears it; every other cause keeps it.

Top module: `reset_hub`

## Requirements
- R1: A high `sw_rst_i` at a rising edge starts a reset and sets `cause_o` to 01.
- R2: A high `wdt_uf_i` starts a reset, with `cause_o` 10, only when `wdt_rst_en_i` is 1. With `wdt_rst_en_i` at 0, `sys_rst_o`, `cpu_en_o`, `cause_o` and `pmode_o` are left unchanged.
- R3: A high `osc_stop_i` with `osc_mode_i` at 0 starts a reset with `cause_o` 11, and holds `sys_rst_o` high and `cpu_en_o` low for as long as `osc_stop_i` stays high. With `osc_mode_i` at 1 it has no effect.
- R4: `pmode_o` keeps its value across software, watchdog and oscillator resets. A pin reset clears it to 00. A write through `mode_we_i` takes effect at the next edge, and only while `cpu_en_o` is 1.
- R5: `sys_rst_o` is high during every reset. `prot_rst_o` is high during a reset only when `cause_o` is 00 (pin), and is 0 otherwise.
- R6: `pin_rst_ni` passes through a two-flop synchroniser. A low level sampled at a rising edge drives `sys_rst_o` high from the third rising edge on.
- R7: `sys_rst_o` stays high for exactly 4 (`STRETCH`) cycles after the last cycle in which any cause is active, and falls at a clock edge.
- R8: When causes coincide, the recorded cause follows the priority pin (00), oscillator stop (11), watchdog (10), software (01). `cause_o` holds the last cause until the next reset.
- R9: After release, the block reads address FFFFCh and then FFFFEh, holding `bus_req_o` until `bus_ack_i`. It loads `pc_o` as {word at FFFFEh bits 3:0, word at FFFFCh}.
- R10: `cpu_en_o` rises exactly one cycle after the second read is accepted, and is 0 whenever `sys_rst_o` is 1.
- R11: While and just after `rst_ni` is low: `cause_o` 00, `pmode_o` 00, `sys_rst_o` 1, `prot_rst_o` 1, `cpu_en_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| sw_rst_i | input | 1 | Software reset request pulse |
| wdt_uf_i | input | 1 | Watchdog underflow event |
| wdt_rst_en_i | input | 1 | 1 lets watchdog underflow reset |
| osc_stop_i | input | 1 | Main oscillator absent |
| osc_mode_i | input | 1 | 0 lets oscillator stop reset |
| mode_we_i | input | 1 | Processor-mode write strobe |
| mode_d_i | input | 2 | Processor-mode write data |
| bus_ack_i | input | 1 | Vector read accepted |
| bus_rdata_i | input | 16 | Vector read data |
| bus_req_o | output | 1 | Vector read request |
| bus_addr_o | output | 20 | Vector read address |
| sys_rst_o | output | 1 | Reset for CPU registers, pins and general peripherals |
| prot_rst_o | output | 1 | Reset for the protected peripheral group |
| cpu_en_o | output | 1 | CPU may run |
| pc_o | output | 20 | Start address from the vector |
| cause_o | output | 2 | Last reset cause |
| pmode_o | output | 2 | Processor-mode field |

## Verification
A software, watchdog or oscillator cause present at edge E0 shows on `sys_rst_o` and `cause_o` at the sample after E0. A pin cause shows two edges later, because of the synchroniser. Release follows four edges after the last active cycle of the cause (six for the pin, counted from the removal of the stimulus). Each read then completes at the edge after its acknowledge. `cpu_en_o` follows one edge after the second read. Inputs change away from the sampling point and outputs are read on falling edges. The bench counts high samples of `sys_rst_o` from the moment a cause is removed and compares them with 4 or 6. It tracks handshakes sample by sample, so acknowledge delays of random length never shift an expected value.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  typedef enum logic [1:0] {
    CAUSE_PIN = 2'd0,
    CAUSE_SW  = 2'd1,
    CAUSE_WDT = 2'd2,
    CAUSE_OSC = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_HOLD,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_RUN
  } seq_e;
endpackage

// File: rtl/reset_hub_sync.sv
module reset_hub_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/reset_hub_arb.sv
module reset_hub_arb
  import reset_hub_pkg::*;
#(
  parameter int MW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_act_i,
  input  logic          sw_i,
  input  logic          wdt_uf_i,
  input  logic          wdt_en_i,
  input  logic          osc_stop_i,
  input  logic          osc_mode_i,
  input  logic          mode_we_i,
  input  logic [MW-1:0] mode_d_i,
  input  logic          run_i,
  output logic          trig_o,
  output cause_e        cause_o,
  output logic [MW-1:0] pmode_o
);
  logic   osc_evt, wdt_evt;
  cause_e cause_d, cause_q;
  logic [MW-1:0] pmode_q;

  assign osc_evt = osc_stop_i & ~osc_mode_i;
  assign wdt_evt = wdt_uf_i & wdt_en_i;
  assign trig_o  = pin_act_i | osc_evt | wdt_evt | sw_i;

  always_comb begin
    if (pin_act_i)    cause_d = CAUSE_PIN;
    else if (osc_evt) cause_d = CAUSE_OSC;
    else if (wdt_evt) cause_d = CAUSE_WDT;
    else if (sw_i)    cause_d = CAUSE_SW;
    else              cause_d = cause_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_PIN;
      pmode_q <= '0;
    end else begin
      if (trig_o) cause_q <= cause_d;
      if (pin_act_i)                           pmode_q <= '0;
      else if (mode_we_i && run_i && !trig_o)  pmode_q <= mode_d_i;
    end
  end

  assign cause_o = cause_q;
  assign pmode_o = pmode_q;

  assert_pin_clears_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act_i |=> pmode_o == '0);
  assert_keep_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_stop_i || wdt_uf_i || sw_i) && !pin_act_i && !run_i |=> $stable(pmode_o));
  assert_osc_over_wdt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_stop_i && !osc_mode_i && !pin_act_i) |=> cause_o == CAUSE_OSC);
  assert_wdt_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_uf_i && !wdt_en_i && !pin_act_i && !(osc_stop_i && !osc_mode_i) && !sw_i)
      |=> $stable(cause_o));
  assert_sw_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_i && !pin_act_i && !(osc_stop_i && !osc_mode_i) && !(wdt_uf_i && wdt_en_i))
      |=> cause_o == CAUSE_SW);
endmodule

// File: rtl/reset_hub_seq.sv
module reset_hub_seq
  import reset_hub_pkg::*;
#(
  parameter int            STRETCH  = 4,
  parameter int            AW       = 20,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] VEC_ADDR = 20'hFFFFC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          hold_o,
  output logic          run_o,
  output logic [AW-1:0] pc_o
);
  localparam int            CW      = (STRETCH > 1) ? $clog2(STRETCH) : 1;
  localparam logic [CW-1:0] LAST    = CW'(STRETCH - 1);
  localparam int            HW      = AW - DW;
  localparam logic [AW-1:0] VEC_HI  = VEC_ADDR + AW'(2);
  localparam int            KW      = CW + 2;
  localparam logic [KW-1:0] KSAT    = KW'(STRETCH + 1);

  seq_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] lo_q;
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
      lo_q  <= '0;
      pc_q  <= '0;
    end else if (trig_i) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          if (cnt_q == LAST) st_q  <= ST_VEC_LO;
          else               cnt_q <= cnt_q + 1'b1;
        end
        ST_VEC_LO: if (bus_ack_i) begin
          lo_q <= bus_rdata_i;
          st_q <= ST_VEC_HI;
        end
        ST_VEC_HI: if (bus_ack_i) begin
          pc_q <= {bus_rdata_i[HW-1:0], lo_q};
          st_q <= ST_RUN;
        end
        default: ;
      endcase
    end
  end

  assign hold_o     = (st_q == ST_HOLD);
  assign run_o      = (st_q == ST_RUN);
  assign bus_req_o  = (st_q == ST_VEC_LO) || (st_q == ST_VEC_HI);
  assign bus_addr_o = (st_q == ST_VEC_HI) ? VEC_HI : VEC_ADDR;
  assign pc_o       = pc_q;

  // checker: hold cycles since the last trigger cycle
  logic [KW-1:0] hold_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hold_cnt_q <= KW'(1);
    else if (trig_i)                     hold_cnt_q <= KW'(1);
    else if (hold_o && hold_cnt_q != KSAT) hold_cnt_q <= hold_cnt_q + 1'b1;
  end

  assert_stretch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> hold_cnt_q >= KSAT);
  assert_en_after_reads_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(bus_req_o && bus_ack_i && bus_addr_o == VEC_HI));
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int            STRETCH  = 4,
  parameter int            AW       = 20,
  parameter int            DW       = 16,
  parameter int            MW       = 2,
  parameter int            SYNC     = 2,
  parameter logic [AW-1:0] VEC_ADDR = 20'hFFFFC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_rst_ni,
  input  logic          sw_rst_i,
  input  logic          wdt_uf_i,
  input  logic          wdt_rst_en_i,
  input  logic          osc_stop_i,
  input  logic          osc_mode_i,
  input  logic          mode_we_i,
  input  logic [MW-1:0] mode_d_i,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          sys_rst_o,
  output logic          prot_rst_o,
  output logic          cpu_en_o,
  output logic [AW-1:0] pc_o,
  output logic [1:0]    cause_o,
  output logic [MW-1:0] pmode_o
);
  logic   pin_s_n, trig, hold, run;
  cause_e cause;

  reset_hub_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_rst_ni),
    .q_o   (pin_s_n)
  );

  reset_hub_arb #(.MW(MW)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_act_i (~pin_s_n),
    .sw_i      (sw_rst_i),
    .wdt_uf_i  (wdt_uf_i),
    .wdt_en_i  (wdt_rst_en_i),
    .osc_stop_i(osc_stop_i),
    .osc_mode_i(osc_mode_i),
    .mode_we_i (mode_we_i),
    .mode_d_i  (mode_d_i),
    .run_i     (run),
    .trig_o    (trig),
    .cause_o   (cause),
    .pmode_o   (pmode_o)
  );

  reset_hub_seq #(.STRETCH(STRETCH), .AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .bus_ack_i  (bus_ack_i),
    .bus_rdata_i(bus_rdata_i),
    .bus_req_o  (bus_req_o),
    .bus_addr_o (bus_addr_o),
    .hold_o     (hold),
    .run_o      (run),
    .pc_o       (pc_o)
  );

  assign sys_rst_o  = hold;
  assign prot_rst_o = hold && (cause == CAUSE_PIN);
  assign cpu_en_o   = run;
  assign cause_o    = cause;

  assert_osc_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_stop_i && !osc_mode_i) |=> sys_rst_o && !cpu_en_o);
endmodule

// File: tb/reset_hub_tb.sv
module reset_hub_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] A_LO = 20'hFFFFC;
  localparam logic [19:0] A_HI = 20'hFFFFE;

  logic clk = 1'b0;
  logic rst_ni, pin_rst_ni, sw_rst_i, wdt_uf_i, wdt_rst_en_i, osc_stop_i, osc_mode_i;
  logic mode_we_i, bus_ack_i, bus_req_o, sys_rst_o, prot_rst_o, cpu_en_o;
  logic [1:0]  mode_d_i, cause_o, pmode_o;
  logic [15:0] bus_rdata_i;
  logic [19:0] bus_addr_o, pc_o;

  logic [15:0] vlo, vhi;
  logic        ack_ok = 1'b1;
  logic        rand_ack = 1'b0;
  logic [1:0]  cur_mode, cur_cause;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_ack_i   = bus_req_o & ack_ok;
  assign bus_rdata_i = (bus_addr_o == A_HI) ? vhi : vlo;

  reset_hub u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_rst_ni(pin_rst_ni), .sw_rst_i(sw_rst_i),
    .wdt_uf_i(wdt_uf_i), .wdt_rst_en_i(wdt_rst_en_i), .osc_stop_i(osc_stop_i),
    .osc_mode_i(osc_mode_i), .mode_we_i(mode_we_i), .mode_d_i(mode_d_i),
    .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i), .bus_req_o(bus_req_o),
    .bus_addr_o(bus_addr_o), .sys_rst_o(sys_rst_o), .prot_rst_o(prot_rst_o),
    .cpu_en_o(cpu_en_o), .pc_o(pc_o), .cause_o(cause_o), .pmode_o(pmode_o)
  );

  initial forever begin
    @(posedge clk);
    #1 ack_ok = rand_ack ? ($urandom_range(0, 1) == 1) : 1'b1;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cause(input logic p, o, om, w, we, s, input logic [1:0] prev);
    if (p)            return 2'd0;
    if (o && !om)     return 2'd3;
    if (w && we)      return 2'd2;
    if (s)            return 2'd1;
    return prev;
  endfunction

  task automatic fire(input logic p, s, w, we, o, om, input int len);
    wdt_rst_en_i = we; osc_mode_i = om;
    pin_rst_ni = ~p; sw_rst_i = s; wdt_uf_i = w; osc_stop_i = o;
    repeat (len) @(negedge clk);
    pin_rst_ni = 1'b1; sw_rst_i = 1'b0; wdt_uf_i = 1'b0; osc_stop_i = 1'b0;
  endtask

  task automatic observe(input int exp_hold, input logic [1:0] ec, input logic [1:0] em,
                         input logic ep, input string tag);
    int n = 0;
    int bad_prot = 0;
    int reads = 0;
    int bad_addr = 0;
    int guard = 0;
    logic prev_hs = 1'b0;
    while (sys_rst_o && n < 5000) begin
      if (prot_rst_o !== ep || cpu_en_o) bad_prot++;
      n++;
      @(negedge clk);
    end
    chk(n == exp_hold, "R7", {tag, " stretch cycles"}, n, exp_hold);
    chk(bad_prot == 0, "R5", {tag, " protected reset / enable during reset"}, bad_prot, 0);
    while (!cpu_en_o && guard < 500) begin
      prev_hs = 1'b0;
      if (bus_req_o && bus_ack_i) begin
        if (bus_addr_o !== ((reads == 0) ? A_LO : A_HI)) bad_addr++;
        reads++;
        prev_hs = 1'b1;
      end
      guard++;
      @(negedge clk);
    end
    chk(reads == 2 && bad_addr == 0, "R9", {tag, " vector reads"}, reads, 2);
    chk(prev_hs, "R10", {tag, " enable one cycle after second read"}, prev_hs, 1);
    chk(pc_o == {vhi[3:0], vlo}, "R9", {tag, " start address"}, pc_o, {vhi[3:0], vlo});
    chk(cause_o == ec, "R8", {tag, " cause"}, cause_o, ec);
    chk(pmode_o == em, "R4", {tag, " mode field"}, pmode_o, em);
    cur_cause = ec;
    cur_mode  = em;
  endtask

  task automatic expect_quiet(input string req, input string tag);
    int bad = 0;
    repeat (6) begin
      if (sys_rst_o || !cpu_en_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, {tag, " no reset"}, bad, 0);
    chk(cause_o == cur_cause, req, {tag, " cause unchanged"}, cause_o, cur_cause);
    chk(pmode_o == cur_mode, req, {tag, " mode unchanged"}, pmode_o, cur_mode);
  endtask

  task automatic write_mode(input logic [1:0] v);
    mode_d_i = v; mode_we_i = 1'b1;
    @(negedge clk);
    mode_we_i = 1'b0;
    chk(pmode_o == v, "R4", "mode write while running", pmode_o, v);
    cur_mode = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [1:0] v;
    int unsigned seed_v;
    seed_v = $urandom(32'h1d5);
    rst_ni = 1'b0; pin_rst_ni = 1'b1; sw_rst_i = 1'b0; wdt_uf_i = 1'b0; wdt_rst_en_i = 1'b0;
    osc_stop_i = 1'b0; osc_mode_i = 1'b1; mode_we_i = 1'b0; mode_d_i = 2'd0;
    vlo = 16'h1234; vhi = 16'hABC5;
    cur_mode = 2'd0; cur_cause = 2'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R11 reset state
    chk(sys_rst_o && prot_rst_o && !cpu_en_o, "R11", "reset outputs",
        {sys_rst_o, prot_rst_o, cpu_en_o}, 3'b110);
    chk(cause_o == 2'd0 && pmode_o == 2'd0, "R11", "reset cause/mode", {cause_o, pmode_o}, 0);
    observe(4, 2'd0, 2'd0, 1'b1, "boot");

    // R1 software
    write_mode(2'd2);
    vlo = 16'h0F0F; vhi = 16'h0003;
    fire(0, 1, 0, 0, 0, 1, 1);
    observe(4, 2'd1, 2'd2, 1'b0, "R1 software");

    // R2 watchdog enabled / disabled
    fire(0, 0, 1, 1, 0, 1, 2);
    observe(4, 2'd2, 2'd2, 1'b0, "R2 watchdog");
    fire(0, 0, 1, 0, 0, 1, 3);
    expect_quiet("R2", "watchdog disabled");

    // R3 oscillator held, then disabled
    write_mode(2'd1);
    begin
      int bad = 0;
      wdt_rst_en_i = 1'b0; osc_mode_i = 1'b0; osc_stop_i = 1'b1;
      @(negedge clk);
      repeat (20) begin
        if (!sys_rst_o || cpu_en_o) bad++;
        @(negedge clk);
      end
      osc_stop_i = 1'b0;
      chk(bad == 0, "R3", "held while oscillator absent", bad, 0);
    end
    observe(4, 2'd3, 2'd1, 1'b0, "R3 oscillator");
    fire(0, 0, 0, 0, 1, 1, 3);
    expect_quiet("R3", "oscillator reset disabled");

    // R4 mode write ignored during reset
    fire(0, 1, 0, 0, 0, 1, 1);
    mode_d_i = 2'd2; mode_we_i = 1'b1;
    @(negedge clk);
    mode_we_i = 1'b0;
    observe(3, 2'd1, 2'd1, 1'b0, "R4 write during reset");

    // R6 pin synchroniser latency, R5 protected reset, R4 clear
    pin_rst_ni = 1'b0;
    @(negedge clk); chk(!sys_rst_o, "R6", "after 1st edge", sys_rst_o, 0);
    @(negedge clk); chk(!sys_rst_o, "R6", "after 2nd edge", sys_rst_o, 0);
    @(negedge clk); chk(sys_rst_o, "R6", "after 3rd edge", sys_rst_o, 1);
    @(negedge clk);
    pin_rst_ni = 1'b1;
    observe(6, 2'd0, 2'd0, 1'b1, "R6 pin");

    // R8 priority
    write_mode(2'd3);
    fire(1, 1, 1, 1, 1, 0, 3);
    observe(6, 2'd0, 2'd0, 1'b1, "R8 all sources");
    write_mode(2'd1);
    fire(0, 1, 1, 1, 1, 0, 1);
    observe(4, 2'd3, 2'd1, 1'b0, "R8 osc over wdt");
    fire(0, 1, 1, 1, 0, 0, 2);
    observe(4, 2'd2, 2'd1, 1'b0, "R8 wdt over sw");

    // constrained random with random acknowledge delays
    rand_ack = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic p, o, om, w, we, s, eff;
      logic [1:0] ec;
      int len;
      v = 2'($urandom_range(0, 3));
      write_mode(v);
      vlo = 16'($urandom); vhi = 16'($urandom);
      p  = ($urandom_range(0, 4) == 0);
      o  = 1'($urandom); om = 1'($urandom);
      w  = 1'($urandom); we = 1'($urandom);
      s  = ($urandom_range(0, 2) == 0);
      eff = p | (o & ~om) | (w & we) | s;
      ec  = exp_cause(p, o, om, w, we, s, cur_cause);
      len = p ? 3 + $urandom_range(0, 2) : 1 + $urandom_range(0, 2);
      fire(p, s, w, we, o, om, len);
      if (eff) observe(p ? 6 : 4, ec, p ? 2'd0 : cur_mode, p, "random");
      else     expect_quiet("R2", "random gated sources");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule